// File: doc/BRIEF.md
# Instruction Sequencer with Two-Word Handling

This unit sets the pace and the address flow of a processor with 16-bit program words. Every four input clocks it closes one instruction cycle with a single-clock strobe. At that edge it moves the program counter, registers the freshly fetched word for execution, and decides whether the next cycle runs that word or a bubble in its place. The address output is byte-based and steps by two per fetched word.

Fetch and execute overlap. While one word executes, the next word is already being read at `pc`. The unit handles these cases itself: conditional branches on the ALU flags, the two relative jumps (a plain jump and a jump that also calls), and the two absolute jumps that span two words. A taken transfer discards the word already fetched, so it costs two cycles. A skip request from the execute stage discards the next word in the same way. When the skipped word is the head of a two-word instruction, its tail (top nibble `4'hF`) then executes as a no-op on its own, so the skip costs three cycles in total. For each call, the unit sends the return stack a one-clock push request.

Top module: `insn_seq_unit`

## Requirements
- R1: `cyc_strobe` is high for exactly one clock in every four. Its first pulse falls in the fourth clock after reset is released, and every later pulse comes four clocks after the one before.
- R2: While reset is held, `pc` equals `RESET_PC` (default 0), `nop_sub` is 1, and `cyc_strobe` and `call_push` are 0. The first cycle after reset executes a bubble.
- R3: `pc` changes only at the clock edge that ends a strobe clock. With no transfer and no skip, it then rises by 2.
- R4: `nop_sub` is high for a whole instruction cycle when the word executing in that cycle is a flushed word, or when its bits 15:12 are `4'hF`. Otherwise it is low.
- R5: A word with bits 15:11 = `5'b11100` is a conditional branch. Its condition code is in bits 10:8: 0 zero, 1 not zero, 2 carry, 3 not carry, 4 overflow, 5 not overflow, 6 negative, 7 not negative. The flags are laid out as `flags[0]` carry, `flags[1]` zero, `flags[2]` overflow, `flags[3]` negative. When the condition is met, the new `pc` is the current `pc` plus twice the sign-extended 8-bit offset in bits 7:0.
- R6: A word with bits 15:11 = `5'b11010` (jump) or `5'b11011` (jump with call) is always taken. The new `pc` is the current `pc` plus twice the sign-extended 11-bit offset in bits 10:0.
- R7: A first word with bits 15:8 = `8'hEF` (jump), or with bits 15:9 = `7'b1110110` (call), combines with the fetched second word. The new `pc` is `{second[11:0], first[7:0], 1'b0}`.
- R8: Every taken transfer (R5, R6, R7) replaces the already-fetched word with a bubble, so the transfer takes two instruction cycles.
- R9: `skip_req`, sampled at the strobe of a live, non-transferring cycle, turns the next word into a bubble while `pc` still advances by 2. Skipping a two-word head therefore yields two bubble cycles in a row.
- R10: `call_push` is high only in the strobe clock of a live cycle that executes a call (the jump with call of R6, or the call of R7).
- R11: In a bubble cycle, `skip_req` and the flags have no effect. A taken transfer overrides `skip_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_word | input | 16 | Program word read at `pc` |
| flags | input | 4 | ALU condition flags {negative, overflow, zero, carry} |
| skip_req | input | 1 | Skip condition true for the executing word |
| pc | output | PC_W (21) | Byte address of the word being fetched |
| nop_sub | output | 1 | Current cycle executes as a no-op |
| cyc_strobe | output | 1 | Last clock of an instruction cycle |
| call_push | output | 1 | Return-stack push request |

## Verification
The embedded properties check, on every clock, that the strobe cadence holds and that `pc` moves only at a strobe edge. They also check that an unflushed cycle steps `pc` by exactly two, that any flush leaves the following cycle marked as a no-op, and that a push is always followed by a bubble. Several behaviours show only in the bench's scenarios: the correct branch targets for each condition code and offset sign, the assembly of the 20-bit absolute target from two words, the three-cycle cost of skipping a two-word head, and the suppression of skips and flags during bubbles. The bench checks these against its own cycle model, running over a random program laced with a directed skip over an absolute jump.

// File: rtl/seq_pkg.sv
package seq_pkg;

  localparam int WORD_W = 16;

  // bit positions of the condition flags input
  localparam int FLG_CARRY = 0;
  localparam int FLG_ZERO  = 1;
  localparam int FLG_OVF   = 2;
  localparam int FLG_NEG   = 3;
  localparam int FLG_W     = 4;

  typedef enum logic [2:0] {
    XF_NONE  = 3'd0,
    XF_COND  = 3'd1,
    XF_JREL  = 3'd2,
    XF_CREL  = 3'd3,
    XF_JABS  = 3'd4,
    XF_CABS  = 3'd5
  } xfer_kind_e;

  // classify a word by its upper byte
  function automatic xfer_kind_e classify(input logic [7:0] hi);
    if (hi == 8'hEF)                 return XF_JABS;
    else if (hi[7:1] == 7'b1110110)  return XF_CABS;
    else if (hi[7:3] == 5'b11010)    return XF_JREL;
    else if (hi[7:3] == 5'b11011)    return XF_CREL;
    else if (hi[7:3] == 5'b11100)    return XF_COND;
    else                             return XF_NONE;
  endfunction

  // evaluate a 3-bit condition code against the flags
  function automatic logic cond_met(input logic [2:0] cc, input logic [FLG_W-1:0] f);
    logic sel;
    case (cc[2:1])
      2'b00:   sel = f[FLG_ZERO];
      2'b01:   sel = f[FLG_CARRY];
      2'b10:   sel = f[FLG_OVF];
      default: sel = f[FLG_NEG];
    endcase
    return sel ^ cc[0];
  endfunction

endpackage

// File: rtl/seq_phase_gen.sv
module seq_phase_gen #(
  parameter int PHASES = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic strobe
);
  localparam int PH_W = (PHASES > 1) ? $clog2(PHASES) : 1;
  localparam logic [PH_W-1:0] LAST = PH_W'(PHASES - 1);

  logic [PH_W-1:0] phase;

  always_ff @(posedge clk) begin
    if (!rst_n)              phase <= '0;
    else if (phase == LAST)  phase <= '0;
    else                     phase <= phase + PH_W'(1);
  end

  assign strobe = rst_n && (phase == LAST);

  // R1: one strobe clock, then quiet
  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);
  // R1: cadence of PHASES clocks
  a_r1_cadence: assert property (@(posedge clk) disable iff (!rst_n)
    $past(strobe, 4) |-> strobe);

endmodule

// File: rtl/seq_decode.sv
module seq_decode
  import seq_pkg::*;
(
  input  logic [7:0]       opc_hi,
  input  logic [FLG_W-1:0] flags,
  input  logic             live,
  output xfer_kind_e       kind,
  output logic             xfer,
  output logic             is_call
);
  logic taken_if_live;

  always_comb begin
    kind = classify(opc_hi);
    case (kind)
      XF_COND:                         taken_if_live = cond_met(opc_hi[2:0], flags);
      XF_JREL, XF_CREL, XF_JABS, XF_CABS: taken_if_live = 1'b1;
      default:                         taken_if_live = 1'b0;
    endcase
    xfer    = live && taken_if_live;
    is_call = live && (kind == XF_CREL || kind == XF_CABS);
  end

endmodule

// File: rtl/seq_target.sv
module seq_target
  import seq_pkg::*;
#(
  parameter int PC_W = 21
) (
  input  logic [PC_W-1:0] pc_now,
  input  xfer_kind_e      kind,
  input  logic [10:0]     low_bits,
  input  logic [11:0]     tail_bits,
  output logic [PC_W-1:0] target
);
  localparam int ABS_W = 12 + 8 + 1;

  // relative: twice the signed offset added to the next address
  function automatic logic [PC_W-1:0] rel8(input logic [PC_W-1:0] base, input logic [7:0] off);
    logic [PC_W-1:0] ext;
    ext = {{(PC_W-8){off[7]}}, off};
    return base + (ext << 1);
  endfunction

  function automatic logic [PC_W-1:0] rel11(input logic [PC_W-1:0] base, input logic [10:0] off);
    logic [PC_W-1:0] ext;
    ext = {{(PC_W-11){off[10]}}, off};
    return base + (ext << 1);
  endfunction

  // absolute: word address built from two program words
  function automatic logic [PC_W-1:0] abs20(input logic [11:0] hi, input logic [7:0] lo);
    logic [ABS_W-1:0] a;
    a = {hi, lo, 1'b0};
    return PC_W'(a);
  endfunction

  always_comb begin
    case (kind)
      XF_COND:          target = rel8(pc_now, low_bits[7:0]);
      XF_JREL, XF_CREL: target = rel11(pc_now, low_bits);
      XF_JABS, XF_CABS: target = abs20(tail_bits, low_bits[7:0]);
      default:          target = pc_now;
    endcase
  end

endmodule

// File: rtl/insn_seq_unit.sv
module insn_seq_unit
  import seq_pkg::*;
#(
  parameter int              PC_W     = 21,
  parameter int              PHASES   = 4,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       prog_word,
  input  logic [3:0]        flags,
  input  logic              skip_req,
  output logic [PC_W-1:0]   pc,
  output logic              nop_sub,
  output logic              cyc_strobe,
  output logic              call_push
);
  localparam logic [PC_W-1:0] STEP = PC_W'(2);

  logic [WORD_W-1:0] exec_word;
  logic              exec_killed;
  logic              live;
  xfer_kind_e        kind;
  logic              xfer;
  logic              is_call;
  logic              skip_hit;
  logic              flush;
  logic [PC_W-1:0]   target;

  seq_phase_gen #(.PHASES(PHASES)) u_phase (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (cyc_strobe)
  );

  assign live = !exec_killed;

  seq_decode u_dec (
    .opc_hi  (exec_word[15:8]),
    .flags   (flags),
    .live    (live),
    .kind    (kind),
    .xfer    (xfer),
    .is_call (is_call)
  );

  seq_target #(.PC_W(PC_W)) u_tgt (
    .pc_now    (pc),
    .kind      (kind),
    .low_bits  (exec_word[10:0]),
    .tail_bits (prog_word[11:0]),
    .target    (target)
  );

  // skip applies only to a live word that does not transfer
  assign skip_hit = live && skip_req && !xfer;
  assign flush    = xfer || skip_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc          <= RESET_PC;
      exec_word   <= '0;
      exec_killed <= 1'b1;
    end else if (cyc_strobe) begin
      pc          <= xfer ? target : pc + STEP;
      exec_word   <= prog_word;
      exec_killed <= flush;
    end
  end

  assign nop_sub   = exec_killed || (exec_word[15:12] == 4'hF);
  assign call_push = cyc_strobe && is_call;

  // R3: pc frozen between strobes
  a_r3_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cyc_strobe) |-> $stable(pc));
  // R3: unflushed cycle advances by one word
  a_r3_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cyc_strobe) && !$past(flush)) |-> (pc == $past(pc) + STEP));
  // R8 / R9: any flush leaves a bubble behind it
  a_r8_flush_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cyc_strobe) && $past(flush)) |-> nop_sub);
  // R10: a push is followed by a bubble cycle
  a_r10_push_then_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    call_push |=> nop_sub);
  // R11: a bubble never requests a push
  a_r11_bubble_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_killed && cyc_strobe) |-> !call_push);

endmodule

// File: tb/insn_seq_unit_test.sv
`timescale 1ns/1ps
module insn_seq_unit_test;
  localparam int PC_W = 21;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [15:0]     prog_word = '0;
  logic [3:0]      flags = '0;
  logic            skip_req = 1'b0;
  logic [PC_W-1:0] pc;
  logic            nop_sub, cyc_strobe, call_push;

  always #4 clk = ~clk;

  insn_seq_unit uut (
    .clk(clk), .rst_n(rst_n), .prog_word(prog_word), .flags(flags),
    .skip_req(skip_req), .pc(pc), .nop_sub(nop_sub),
    .cyc_strobe(cyc_strobe), .call_push(call_push)
  );

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;
  logic [15:0] mem [64];

  logic [PC_W-1:0] m_pc;
  logic [15:0]     m_ir;
  logic            m_kill;
  string           m_tag, m_why;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit f_cond(input logic [2:0] cc, input logic [3:0] f);
    case (cc)
      3'd0: return f[1];
      3'd1: return !f[1];
      3'd2: return f[0];
      3'd3: return !f[0];
      3'd4: return f[2];
      3'd5: return !f[2];
      3'd6: return f[3];
      default: return !f[3];
    endcase
  endfunction

  function automatic logic [PC_W-1:0] f_rel(input logic [PC_W-1:0] base, input int off);
    return base + PC_W'(off * 2);
  endfunction

  function automatic logic [PC_W-1:0] f_abs(input logic [15:0] w2, input logic [15:0] w1);
    logic [31:0] wa;
    wa = {12'd0, w2[11:0], w1[7:0]};
    return PC_W'(wa * 2);
  endfunction

  task automatic gen_program();
    int i = 0;
    while (i < 64) begin
      int r = $urandom % 10;
      logic [15:0] w = 16'($urandom);
      if (r >= 7 && i == 63) r = 0;
      case (r)
        4: mem[i] = {5'b11100, w[10:0]};
        5: mem[i] = {5'b11010, w[10:0]};
        6: mem[i] = {5'b11011, w[10:0]};
        7: begin mem[i] = {8'hEF, w[7:0]}; i++; mem[i] = {4'hF, 12'($urandom)}; end
        8: begin mem[i] = {7'b1110110, w[8:0]}; i++; mem[i] = {4'hF, 12'($urandom)}; end
        9: begin
          if (w[15]) begin mem[i] = {12'hEE0, 2'b00, w[1:0]}; i++; mem[i] = {8'hF0, w[7:0]}; end
          else mem[i] = {4'hF, w[11:0]};
        end
        default: mem[i] = {4'(w[15:12] % 13), w[11:0]};
      endcase
      i++;
    end
    // directed head: plain, plain (skipped over next), absolute jump pair
    mem[0] = 16'h0E12;
    mem[1] = 16'h2A00;
    mem[2] = 16'hEF05;
    mem[3] = 16'hF000;
  endtask

  // one instruction cycle of the reference behaviour
  task automatic model_step();
    logic [15:0] w = m_ir;
    logic [15:0] nw = prog_word;
    bit live = !m_kill;
    bit take = 0, sk;
    logic [PC_W-1:0] tgt = m_pc;
    string tag = "R3";
    bit e_nop = m_kill || (w[15:12] == 4'hF);
    bit e_push = live && ((w[15:9] == 7'b1110110) || (w[15:11] == 5'b11011));
    chk(nop_sub === e_nop, m_kill ? m_why : "R4", "nop_sub", nop_sub, e_nop);
    chk(call_push === e_push, "R10", "call_push", call_push, e_push);
    if (live) begin
      if (w[15:8] == 8'hEF || w[15:9] == 7'b1110110) begin
        take = 1; tgt = f_abs(nw, w); tag = "R7";
      end else if (w[15:11] == 5'b11010 || w[15:11] == 5'b11011) begin
        take = 1; tgt = f_rel(m_pc, int'($signed(w[10:0]))); tag = "R6";
      end else if (w[15:11] == 5'b11100) begin
        tag = "R5";
        if (f_cond(w[10:8], flags)) begin take = 1; tgt = f_rel(m_pc, int'($signed(w[7:0]))); end
      end
    end else if (skip_req) tag = "R11";
    if (take && skip_req) tag = "R11";
    sk = live && skip_req && !take;
    if (sk) tag = "R9";
    m_why  = take ? "R8" : "R9";
    m_pc   = take ? tgt : m_pc + PC_W'(2);
    m_ir   = nw;
    m_kill = take || sk;
    m_tag  = tag;
  endtask

  initial begin
    int ph = 0;
    int icyc = 0;
    void'($urandom(32'd20240611));
    gen_program();
    m_pc = '0; m_ir = '0; m_kill = 1'b1; m_tag = "R3"; m_why = "R2";
    repeat (3) @(negedge clk);
    prog_word = mem[0];
    chk(pc === '0, "R2", "reset pc", 32'(pc), 0);
    chk(nop_sub === 1'b1, "R2", "reset nop_sub", 32'(nop_sub), 1);
    chk(cyc_strobe === 1'b0, "R2", "reset strobe", 32'(cyc_strobe), 0);
    chk(call_push === 1'b0, "R2", "reset push", 32'(call_push), 0);
    rst_n = 1'b1;
    flags = 4'($urandom);
    skip_req = 1'b0;
    for (int n = 0; n < 8000; n++) begin
      @(negedge clk);
      ph = (ph + 1) % 4;
      prog_word = mem[pc[6:1]];
      chk(pc === m_pc, m_tag, "pc", 32'(pc), 32'(m_pc));
      chk(cyc_strobe === (ph == 3), "R1", "cyc_strobe", 32'(cyc_strobe), 32'(ph == 3));
      if (ph == 0) begin
        flags = 4'($urandom);
        if (icyc < 8) skip_req = (icyc == 2);
        else          skip_req = ($urandom % 5 == 0);
      end
      if (ph == 3) begin
        model_step();
        icyc++;
      end
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule